// File: doc/BRIEF.md
# Three-State PWM Input Decoder

This block turns a digitized PWM control input into a clean command for a half-bridge gate sequencer. Each clock cycle it takes one unsigned ADC code of the PWM pin voltage and places it in one of three regions: a valid high level, a valid low level, or a mid-level shutdown window. Four threshold inputs, given in ADC codes, set the region edges. They form two hysteresis bands, so a small dip or bump near either level edge does not toggle the decode.

A sample that sits in the window does not act at once. A hold-off counter has to see the window on a set number of consecutive cycles before the valid three-state flag rises. That flag tells the downstream sequencer to turn both gates off. While the hold-off runs, the level command keeps its previous value. Any valid level sample ends the three-state condition on the same clock edge. The command then follows that level: high requests the high-side gate, low requests the low-side gate.

A static check reports threshold settings that are not strictly increasing. Reset starts the decoder in the three-state condition, so both gates are off until a valid level arrives.

Top module: `pwm_tristate_dec`

## Requirements
- R1: While reset is asserted and on its release, `tri_o` = 1, `cmd_o` = 0 and `cfg_err_o` = 0.
- R2: A sample >= `vih_i` gives `cmd_o` = 1 (high-side request) and `tri_o` = 0 after the next clock edge, from any prior state.
- R3: A sample <= `vil_i` that is below `vih_i` gives `cmd_o` = 0 (low-side request) and `tri_o` = 0 after the next clock edge, from any prior state.
- R4: Once decoded high, samples >= `vtri_hi_i` keep the decode high. The hold-off does not start.
- R5: Once decoded low, samples <= `vtri_lo_i` keep the decode low. The hold-off does not start.
- R6: `tri_o` rises on the edge that takes the HOLD_CYC-th consecutive window sample. Until then, and while `tri_o` = 1, `cmd_o` keeps its previous value.
- R7: A valid level sample during a hold-off run clears the count. A later window run needs a full HOLD_CYC samples again.
- R8: While `tri_o` = 1, the first valid level sample clears `tri_o` and sets `cmd_o` to that level on the same edge.
- R9: `cfg_err_o` = 1 one edge after the thresholds fail `vil_i < vtri_lo_i < vtri_hi_i < vih_i`, and 0 one edge after they satisfy it.
- R10: From the window state, samples in (`vil_i`, `vih_i`) count as window, including those inside either hysteresis band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | ADC_W | ADC code of the PWM pin voltage, one per cycle |
| vil_i | input | ADC_W | Low-level entry threshold |
| vtri_lo_i | input | ADC_W | Window entry threshold from low |
| vtri_hi_i | input | ADC_W | Window entry threshold from high |
| vih_i | input | ADC_W | High-level entry threshold |
| cmd_o | output | 1 | Level command, 1 = high-side, 0 = low-side |
| tri_o | output | 1 | Valid three-state flag, both gates off |
| cfg_err_o | output | 1 | Threshold ordering error |

## Verification
All three outputs are registered. A sample or threshold change applied before an edge shows up right after that edge, with one cycle of latency. The bench drives each sample on a falling edge and reads the outputs on the next falling edge, so every check sees the result of exactly one rising edge. For hold-off timing, the bench counts consecutive window samples itself. It expects `tri_o` low after HOLD_CYC-1 of them and high after the HOLD_CYC-th.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  typedef enum logic [1:0] {
    ZN_LOW  = 2'd0,
    ZN_MID  = 2'd1,
    ZN_HIGH = 2'd2
  } zone_e;
endpackage

// File: rtl/tsd_cfg_check.sv
module tsd_cfg_check #(
  parameter int ADC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADC_W-1:0] vil_i,
  input  logic [ADC_W-1:0] vtri_lo_i,
  input  logic [ADC_W-1:0] vtri_hi_i,
  input  logic [ADC_W-1:0] vih_i,
  output logic             err_o
);
  localparam int NTHR = 4;

  logic [ADC_W-1:0] thr [NTHR];
  logic [NTHR-2:0]  pair_ok;
  logic             err_q;

  assign thr[0] = vil_i;
  assign thr[1] = vtri_lo_i;
  assign thr[2] = vtri_hi_i;
  assign thr[3] = vih_i;

  for (genvar i = 0; i < NTHR - 1; i++) begin : g_pair
    assign pair_ok[i] = thr[i] < thr[i+1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= ~&pair_ok;
  end

  assign err_o = err_q;

  p_lo_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vil_i >= vtri_lo_i) |=> err_o);
  p_hi_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtri_hi_i >= vih_i) |=> err_o);
endmodule

// File: rtl/tsd_zone.sv
module tsd_zone
  import tsd_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADC_W-1:0] sample_i,
  input  logic [ADC_W-1:0] vil_i,
  input  logic [ADC_W-1:0] vtri_lo_i,
  input  logic [ADC_W-1:0] vtri_hi_i,
  input  logic [ADC_W-1:0] vih_i,
  output zone_e            zone_nxt_o
);
  zone_e zone_q, zone_d;

  // valid levels win from any state; the bands only matter for the state already held
  always_comb begin
    zone_d = zone_q;
    if (sample_i >= vih_i) begin
      zone_d = ZN_HIGH;
    end else if (sample_i <= vil_i) begin
      zone_d = ZN_LOW;
    end else begin
      unique case (zone_q)
        ZN_HIGH: zone_d = (sample_i >= vtri_hi_i) ? ZN_HIGH : ZN_MID;
        ZN_LOW:  zone_d = (sample_i <= vtri_lo_i) ? ZN_LOW  : ZN_MID;
        default: zone_d = ZN_MID;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zone_q <= ZN_MID;
    else         zone_q <= zone_d;
  end

  assign zone_nxt_o = zone_d;

  p_high_band_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zone_q == ZN_HIGH && sample_i >= vtri_hi_i) |=> zone_q == ZN_HIGH);
  p_low_band_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zone_q == ZN_LOW && sample_i <= vtri_lo_i && sample_i < vih_i) |=> zone_q == ZN_LOW);
  p_mid_stays_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zone_q == ZN_MID && sample_i > vil_i && sample_i < vih_i) |=> zone_q == ZN_MID);
endmodule

// File: rtl/tsd_holdoff.sv
module tsd_holdoff #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_win_i,
  output logic tri_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tri_q;

  // saturating run length of consecutive window samples
  always_comb begin
    if (!in_win_i)             cnt_n = '0;
    else if (cnt_q == HOLD_V)  cnt_n = cnt_q;
    else                       cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= HOLD_V;
      tri_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      tri_q <= in_win_i && (cnt_n == HOLD_V);
    end
  end

  assign tri_o = tri_q;

  initial begin
    if (HOLD_CYC < 1) $error("HOLD_CYC must be at least 1");
  end

  p_rise_after_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tri_q) |-> cnt_q == HOLD_V);
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win_i |=> (!tri_q && cnt_q == '0));
endmodule

// File: rtl/pwm_tristate_dec.sv
module pwm_tristate_dec
  import tsd_pkg::*;
#(
  parameter int ADC_W    = 10,
  parameter int HOLD_CYC = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADC_W-1:0] sample_i,
  input  logic [ADC_W-1:0] vil_i,
  input  logic [ADC_W-1:0] vtri_lo_i,
  input  logic [ADC_W-1:0] vtri_hi_i,
  input  logic [ADC_W-1:0] vih_i,
  output logic             cmd_o,
  output logic             tri_o,
  output logic             cfg_err_o
);
  zone_e zone_nxt;
  logic  cmd_q;

  tsd_zone #(.ADC_W(ADC_W)) i_zone (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_i),
    .vil_i      (vil_i),
    .vtri_lo_i  (vtri_lo_i),
    .vtri_hi_i  (vtri_hi_i),
    .vih_i      (vih_i),
    .zone_nxt_o (zone_nxt)
  );

  tsd_holdoff #(.HOLD_CYC(HOLD_CYC)) i_holdoff (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_win_i (zone_nxt == ZN_MID),
    .tri_o    (tri_o)
  );

  tsd_cfg_check #(.ADC_W(ADC_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vil_i     (vil_i),
    .vtri_lo_i (vtri_lo_i),
    .vtri_hi_i (vtri_hi_i),
    .vih_i     (vih_i),
    .err_o     (cfg_err_o)
  );

  // window samples keep the last level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cmd_q <= 1'b0;
    else if (zone_nxt == ZN_HIGH) cmd_q <= 1'b1;
    else if (zone_nxt == ZN_LOW)  cmd_q <= 1'b0;
  end

  assign cmd_o = cmd_q;

  p_high_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i >= vih_i) |=> (cmd_o && !tri_o));
  p_low_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i <= vil_i && sample_i < vih_i) |=> (!cmd_o && !tri_o));
  p_cmd_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_o |-> $stable(cmd_o));
endmodule

// File: tb/test_pwm_tristate_dec.sv
module test_pwm_tristate_dec;
  localparam int W    = 8;
  localparam int HOLD = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] sample = 8'd100;
  logic [W-1:0] vil = 8'd60, vtri_lo = 8'd70, vtri_hi = 8'd160, vih = 8'd165;
  logic         cmd, tri_s, cfg_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm_tristate_dec #(.ADC_W(W), .HOLD_CYC(HOLD)) i_pwm_tristate_dec (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sample_i  (sample),
    .vil_i     (vil),
    .vtri_lo_i (vtri_lo),
    .vtri_hi_i (vtri_hi),
    .vih_i     (vih),
    .cmd_o     (cmd),
    .tri_o     (tri_s),
    .cfg_err_o (cfg_err)
  );

  // {sample, requirement number, expected cmd, expected tri}; HOLD = 5
  localparam int NV = 23;
  localparam logic [13:0] VEC [NV] = '{
    {8'd200, 4'd8,  1'b1, 1'b0},  // R8 exit reset tri to high
    {8'd162, 4'd4,  1'b1, 1'b0},  // R4 band keeps high
    {8'd160, 4'd4,  1'b1, 1'b0},  // R4 edge of band
    {8'd159, 4'd6,  1'b1, 1'b0},  // R6 window run 1
    {8'd162, 4'd10, 1'b1, 1'b0},  // R10 run 2
    {8'd100, 4'd6,  1'b1, 1'b0},  // R6 run 3
    {8'd65,  4'd10, 1'b1, 1'b0},  // R10 run 4
    {8'd100, 4'd6,  1'b1, 1'b1},  // R6 run 5 -> tri
    {8'd100, 4'd6,  1'b1, 1'b1},  // R6 stays
    {8'd30,  4'd8,  1'b0, 1'b0},  // R8 exit to low
    {8'd68,  4'd5,  1'b0, 1'b0},  // R5 band keeps low
    {8'd70,  4'd5,  1'b0, 1'b0},  // R5 edge of band
    {8'd71,  4'd6,  1'b0, 1'b0},  // R6 run 1
    {8'd71,  4'd6,  1'b0, 1'b0},
    {8'd71,  4'd6,  1'b0, 1'b0},
    {8'd10,  4'd7,  1'b0, 1'b0},  // R7 interrupt
    {8'd100, 4'd7,  1'b0, 1'b0},  // R7 new run 1
    {8'd100, 4'd7,  1'b0, 1'b0},
    {8'd100, 4'd7,  1'b0, 1'b0},
    {8'd100, 4'd7,  1'b0, 1'b0},
    {8'd100, 4'd6,  1'b0, 1'b1},  // R6 run 5 -> tri
    {8'd165, 4'd2,  1'b1, 1'b0},  // R2 exactly vih
    {8'd60,  4'd3,  1'b0, 1'b0}   // R3 exactly vil
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: {cmd,tri,cfg_err} actual %b expected %b", req, act, exp_v);
    end
  endtask

  task automatic step(input logic [W-1:0] s);
    sample = s;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {cmd, tri_s, cfg_err}, 3'b010);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cmd, tri_s, cfg_err}, 3'b010);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13:6]);
      chk($sformatf("R%0d vec %0d", VEC[i][5:2], i), {cmd, tri_s, cfg_err},
          {VEC[i][1], VEC[i][0], 1'b0});
    end

    // R6 at the boundary: HOLD-1 window samples leave tri low
    step(8'd200);
    for (int k = 0; k < HOLD - 1; k++) step(8'd120);
    chk("R6 hold-1", {cmd, tri_s, cfg_err}, 3'b100);
    step(8'd120);
    chk("R6 hold", {cmd, tri_s, cfg_err}, 3'b110);
    step(8'd166);
    chk("R8 exit high", {cmd, tri_s, cfg_err}, 3'b100);

    // R9 ordering errors
    vtri_lo = vil;
    @(negedge clk);
    chk("R9 lo equal", {cmd, tri_s, cfg_err}, 3'b101);
    vtri_lo = 8'd70;
    @(negedge clk);
    chk("R9 restored", {cmd, tri_s, cfg_err}, 3'b100);
    vtri_hi = vih;
    @(negedge clk);
    chk("R9 hi equal", {cmd, tri_s, cfg_err}, 3'b101);
    vtri_hi = 8'd160;
    vtri_lo = 8'd161;
    @(negedge clk);
    chk("R9 mid swap", {cmd, tri_s, cfg_err}, 3'b101);
    vtri_lo = 8'd70;
    @(negedge clk);
    chk("R9 clear", {cmd, tri_s, cfg_err}, 3'b100);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", {cmd, tri_s, cfg_err}, 3'b010);
    rst_ni = 1'b1;
    step(8'd120);
    chk("R1 tri held after reset", {cmd, tri_s, cfg_err}, 3'b010);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule